// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This peripheral gathers a set of level-sensitive interrupt lines and reduces them to one request toward the processor. Software gives every line a priority level and a handler address, and turns lines on and off through separate set and clear enable registers. When the request is raised, the processor reads one vector register. That read returns the handler address of the winning line, so the processor branches to its routine directly, without scanning the lines in software.

The same vector read also acknowledges the interrupt. It pushes the winner's priority onto a small nesting stack, and the top of that stack becomes the current service level. While a routine is in service, any line whose priority is equal to or lower than that level cannot raise the request. A write to the end-of-service register pops the stack and brings back the level that was active before. When no line qualifies, the vector register returns a programmable default address.

All registers sit on a simple word-addressed bus with an address, write data, a write strobe, a read strobe and registered read data. Register offsets (in words): raw status 0x00, masked status 0x01, enable 0x02, enable-set 0x03, enable-clear 0x04, vector 0x05, end-of-service 0x06, default vector 0x07, winner identity 0x08, service level 0x09, per-line priority at 0x40+i, per-line handler address at 0x80+i.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the enables, the stack depth, the service level, the default vector and the read data are all zero, and irq_o is low.
- R2: A read of raw status returns the current src_i levels in bits [NUM_SRC-1:0]. A read of masked status returns src_i AND the enable bits.
- R3: A write to enable-set sets each enable bit whose write-data bit is 1. A write to enable-clear clears each enable bit whose write-data bit is 1. Zero bits leave the enable unchanged, and the enable register reads back the result.
- R4: irq_o is high exactly when some line is pending, enabled and has a priority strictly greater than the current service level, and the stack is not full. The service level is 0 while the stack is empty.
- R5: The read data for any bus read appears on bus_rdata_o in the cycle after the read strobe. A vector read while irq_o is high returns the handler address of the qualifying line with the greatest priority. Ties go to the lowest line index.
- R6: A vector read while no line qualifies returns the default vector and leaves the stack unchanged.
- R7: A vector read while irq_o is high pushes the winner's priority. The service level becomes that priority and the depth grows by one, so lines of equal or lower priority no longer raise irq_o.
- R8: Any write to end-of-service pops one stack entry and restores the previous service level. When the stack is empty, such a write has no effect.
- R9: A read of the identity register returns bit 31 equal to irq_o and, in the low bits, the index of the current winner.
- R10: While the stack holds NEST_DEPTH entries, irq_o is low and a vector read returns the default vector without a push.
- R11: A line with priority 0 never raises irq_o. The service-level register reads the level in bits [PRIO_W-1:0] and the depth in bits starting at bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with eight lines, a three-bit priority and a nesting stack three entries deep. With only eight priority values, random programming produces ties often, so the lowest-index rule is exercised many times. A three-deep stack fills after a few acknowledgements, which brings the full-stack suppression and the default-vector return within reach. A random mix of acknowledgements, end-of-service writes, enable changes and priority rewrites runs against a bench model of the stack, next to directed cases for priority 0, pops on an empty stack and masking at equal priority.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam logic [7:0] OFF_RAW    = 8'h00;
  localparam logic [7:0] OFF_MASKED = 8'h01;
  localparam logic [7:0] OFF_EN     = 8'h02;
  localparam logic [7:0] OFF_ENSET  = 8'h03;
  localparam logic [7:0] OFF_ENCLR  = 8'h04;
  localparam logic [7:0] OFF_VECTOR = 8'h05;
  localparam logic [7:0] OFF_EOS    = 8'h06;
  localparam logic [7:0] OFF_DFLT   = 8'h07;
  localparam logic [7:0] OFF_ID     = 8'h08;
  localparam logic [7:0] OFF_LEVEL  = 8'h09;
  localparam logic [7:0] PRIO_BASE  = 8'h40;
  localparam logic [7:0] VECT_BASE  = 8'h80;
  localparam int         DEPTH_LSB  = 8;
endpackage

// File: rtl/pvi_regs.sv
module pvi_regs #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_q,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    vect_q,
  output logic [DATA_W-1:0]                 dflt_q
);
  import pvi_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      dflt_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFF_ENSET))
        en_q <= en_q | wdata[NUM_SRC-1:0];
      else if (addr == ADDR_W'(OFF_ENCLR))
        en_q <= en_q & ~wdata[NUM_SRC-1:0];
      if (addr == ADDR_W'(OFF_DFLT))
        dflt_q <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        vect_q[i] <= '0;
      end else if (wr_en) begin
        if (addr == ADDR_W'(PRIO_BASE + i)) prio_q[i] <= wdata[PRIO_W-1:0];
        if (addr == ADDR_W'(VECT_BASE + i)) vect_q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              level,
  output logic                           found,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);
  // Upward scan with strict compare: an equal priority at a higher index
  // never displaces the earlier (lower-index) holder.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = level;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pvi_nest_stack.sv
module pvi_nest_stack #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] din,
  output logic [PRIO_W-1:0] level,
  output logic [CNT_W-1:0]  depth,
  output logic              full
);
  logic [DEPTH-1:0][PRIO_W-1:0] stk;
  logic                         empty;

  assign empty = (depth == '0);
  assign full  = (depth == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      stk   <= '0;
    end else if (push && pop && !empty) begin
      for (int k = 0; k < DEPTH; k++)
        if (CNT_W'(k + 1) == depth) stk[k] <= din;
    end else if (push && !full) begin
      for (int k = 0; k < DEPTH; k++)
        if (CNT_W'(k) == depth) stk[k] <= din;
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CNT_W'(k + 1) == depth) level = stk[k];
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC    = 16,
  parameter int PRIO_W     = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int NEST_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  import pvi_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(NEST_DEPTH + 1);

  logic [NUM_SRC-1:0]             en_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0][DATA_W-1:0] vect_q;
  logic [DATA_W-1:0]              dflt_q;
  logic [NUM_SRC-1:0]             masked;
  logic                           found;
  logic [IDX_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_prio;
  logic [PRIO_W-1:0]              cur_level;
  logic [CNT_W-1:0]               stk_depth;
  logic                           stk_full;
  logic                           vec_rd, take, eos_wr;
  logic [DATA_W-1:0]              rd_next, vec_data;

  pvi_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .en_q(en_q), .prio_q(prio_q), .vect_q(vect_q),
    .dflt_q(dflt_q)
  );

  assign masked = src_i & en_q;

  pvi_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend(masked), .prio(prio_q), .level(cur_level),
    .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign irq_o  = found && !stk_full;
  assign vec_rd = bus_rd_i && (bus_addr_i == ADDR_W'(OFF_VECTOR));
  assign take   = vec_rd && irq_o;
  assign eos_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_EOS));

  pvi_nest_stack #(.PRIO_W(PRIO_W), .DEPTH(NEST_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(eos_wr), .din(win_prio),
    .level(cur_level), .depth(stk_depth), .full(stk_full)
  );

  always_comb begin
    vec_data = dflt_q;
    if (irq_o) vec_data = vect_q[win_idx];
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr_i)
      ADDR_W'(OFF_RAW):    rd_next[NUM_SRC-1:0] = src_i;
      ADDR_W'(OFF_MASKED): rd_next[NUM_SRC-1:0] = masked;
      ADDR_W'(OFF_EN):     rd_next[NUM_SRC-1:0] = en_q;
      ADDR_W'(OFF_VECTOR): rd_next = vec_data;
      ADDR_W'(OFF_DFLT):   rd_next = dflt_q;
      ADDR_W'(OFF_ID): begin
        rd_next[DATA_W-1]  = irq_o;
        rd_next[IDX_W-1:0] = win_idx;
      end
      ADDR_W'(OFF_LEVEL): begin
        rd_next[PRIO_W-1:0]          = cur_level;
        rd_next[DEPTH_LSB +: CNT_W]  = stk_depth;
      end
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (bus_addr_i == ADDR_W'(PRIO_BASE + i)) rd_next[PRIO_W-1:0] = prio_q[i];
          if (bus_addr_i == ADDR_W'(VECT_BASE + i)) rd_next = vect_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_next;
  end
endmodule

// File: rtl/pvi_checks.sv
module pvi_checks #(
  parameter int NUM_SRC    = 16,
  parameter int PRIO_W     = 4,
  parameter int ADDR_W     = 8,
  parameter int NEST_DEPTH = 4,
  localparam int CNT_W     = $clog2(NEST_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic               bus_wr_i,
  input logic               bus_rd_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [CNT_W-1:0]   depth,
  input logic [PRIO_W-1:0]  level
);
  import pvi_pkg::*;

  logic ack, eos;
  assign ack = bus_rd_i && (bus_addr_i == ADDR_W'(OFF_VECTOR)) && irq_o;
  assign eos = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_EOS));

  // R4
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(src_i & en_q)));

  // R10
  full_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == CNT_W'(NEST_DEPTH)) |-> !irq_o);

  // R7
  ack_pushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !eos) |=> (depth == CNT_W'($past(depth) + 1'b1)) && (level > $past(level)));

  // R8
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack && depth == '0) |=> (depth == '0));

  // R3
  enable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_i |=> $stable(en_q));

  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(NEST_DEPTH));
endmodule

bind prio_vec_intc pvi_checks #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .NEST_DEPTH(NEST_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .irq_o(irq_o), .en_q(en_q),
  .depth(stk_depth), .level(cur_level)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int PW = 3;
  localparam int ND = 3;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  logic [PW-1:0] m_prio [NS];
  logic [DW-1:0] m_vect [NS];
  logic [NS-1:0] m_en;
  logic [DW-1:0] m_def;
  logic [PW-1:0] m_stk [ND];
  int            m_depth;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc #(.NUM_SRC(NS), .PRIO_W(PW), .DATA_W(DW), .ADDR_W(AW), .NEST_DEPTH(ND)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr_en), .bus_rd_i(rd_en), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [PW-1:0] m_level();
    return (m_depth == 0) ? '0 : m_stk[m_depth-1];
  endfunction

  function automatic int m_winner();
    int best = -1;
    logic [PW-1:0] bp = m_level();
    for (int i = 0; i < NS; i++)
      if (src[i] && m_en[i] && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
    return best;
  endfunction

  function automatic logic m_irq();
    return (m_winner() >= 0) && (m_depth < ND);
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk); src = v; #1;
  endtask

  task automatic chk_irq(string tag);
    #1 check(tag, {31'b0, irq}, {31'b0, m_irq()});
  endtask

  task automatic op_vec(string tag);
    logic [DW-1:0] got, exp;
    int w = m_winner();
    logic take = m_irq();
    exp = take ? m_vect[w] : m_def;
    rd(8'h05, got);
    check(tag, got, exp);
    if (take) begin m_stk[m_depth] = m_prio[w]; m_depth++; end
  endtask

  task automatic op_level(string tag);
    logic [DW-1:0] got;
    rd(8'h09, got);
    check(tag, got, DW'(m_level()) | (DW'(m_depth) << 8));
  endtask

  task automatic op_eos();
    wr(8'h06, $urandom);
    if (m_depth > 0) m_depth--;
    op_level("R8 level after end-of-service");
  endtask

  task automatic op_status();
    logic [DW-1:0] got; int w;
    rd(8'h00, got); check("R2 raw status", got, DW'(src));
    rd(8'h01, got); check("R2 masked status", got, DW'(src & m_en));
    rd(8'h02, got); check("R3 enable readback", got, DW'(m_en));
    w = m_winner();
    rd(8'h08, got);
    check("R9 identity", got, {m_irq(), 28'b0, (w < 0) ? 3'd0 : 3'(w)});
  endtask

  task automatic set_prio(int i, logic [PW-1:0] p);
    wr(AW'(8'h40 + i), DW'(p)); m_prio[i] = p;
  endtask

  task automatic en_set(logic [NS-1:0] v); wr(8'h03, DW'(v)); m_en = m_en | v;  endtask
  task automatic en_clr(logic [NS-1:0] v); wr(8'h04, DW'(v)); m_en = m_en & ~v; endtask

  initial begin
    logic [DW-1:0] got;
    void'($urandom(32'd20240611));
    m_en = '0; m_def = '0; m_depth = 0;
    for (int i = 0; i < NS; i++) begin m_prio[i] = '0; m_vect[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);
    rd(8'h02, got); check("R1 enable after reset", got, 32'd0);
    rd(8'h09, got); check("R1 level after reset", got, 32'd0);
    rd(8'h07, got); check("R1 default after reset", got, 32'd0);

    for (int i = 0; i < NS; i++) begin
      set_prio(i, PW'(i % 5 + 1));
      m_vect[i] = 32'h1000 + 32'(i) * 32'h10;
      wr(AW'(8'h80 + i), m_vect[i]);
    end
    m_def = 32'hDEAD_0000; wr(8'h07, m_def);
    rd(8'h43, got); check("R5 priority readback", got, DW'(m_prio[3]));

    // R6: all pending, none enabled
    set_src('1);
    chk_irq("R4 no enables");
    op_vec("R6 default with nothing enabled");
    op_level("R6 no push");

    // R3 set/clear semantics
    en_set(8'h05); en_set(8'h02); en_clr(8'h01);
    rd(8'h02, got); check("R3 set/clear result", got, 32'h06);
    set_src(8'hA5); op_status();

    // R11 priority zero never interrupts
    en_clr('1); set_prio(3, 0); en_set(8'h08); set_src(8'h08);
    chk_irq("R11 priority zero");

    // R5 tie to lower index
    set_prio(2, 4); set_prio(5, 4); en_set(8'h24); set_src(8'h2C);
    chk_irq("R4 tie irq");
    op_status();
    op_vec("R5 tie goes to lower index");
    op_level("R7 level after ack");
    chk_irq("R7 equal priority masked");
    set_prio(6, 6); en_set(8'h40); set_src(8'h6C);
    chk_irq("R7 higher priority preempts");
    op_vec("R5 nested winner");
    set_prio(7, 7); en_set(8'h80); set_src(8'hEC);
    op_vec("R5 third level");
    op_level("R10 stack full level");
    set_prio(1, 7); en_set(8'h02); set_src(8'hEE);
    chk_irq("R10 full suppresses irq");
    op_vec("R10 default when full");
    op_level("R10 no push when full");
    op_eos(); op_eos(); op_eos();
    op_eos();  // R8 pop on empty stack
    chk_irq("R8 after pops");

    // random phase
    for (int it = 0; it < 600; it++) begin
      case ($urandom_range(0, 7))
        0, 1: op_vec("R5 random vector");
        2: op_eos();
        3: en_set(NS'($urandom));
        4: en_clr(NS'($urandom));
        5: set_prio($urandom_range(0, NS-1), PW'($urandom));
        6: set_src(NS'($urandom));
        default: op_status();
      endcase
      chk_irq("R4 random irq");
    end
    summary();
  end
endmodule